// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 10-bit digital-to-analog converter that sits on a processor bus. It holds two registers in series. The first is an input stage that collects a new code. The second is an output register that holds the code the converter is currently producing. Because new data can be staged while the old code stays on the output, several converters can all be loaded ahead of time. A single shared transfer strobe then moves every staged code to its output in the same clock cycle.

The input stage has a wide upper section and a narrow lower section. A full-width write fills both sections. A processor with a bus one byte wide uses two writes instead. The first write, made with the byte-select input high, supplies the upper eight bits on the top eight data lines; data is left justified. The second write, made with byte-select low, overwrites only the two low bits, which it takes from the two most significant data lines.

All controls act on their level and are sampled on the rising clock edge:
- Chip select is active low.
- Write is active low and is gated by chip select.
- Transfer is active low and works only while byte-select is low.

Tying write and transfer active gives a flow-through path. Tying only transfer active gives a single-buffered path.

Top module: `dbdac_front`

## Requirements
- R1: With `rst` high at a clock edge, the input stage and `code` are both cleared to zero at that edge.
- R2: While `cs_n` is high, a low `wr_n` changes nothing in the input stage.
- R3: A write (`cs_n` and `wr_n` low) with `bsel` high loads all of `din[9:0]` into the input stage. `din[9]` is the most significant bit and `din[0]` the least.
- R4: A write with `bsel` low replaces only input-stage bits 1:0, taking bit 1 from `din[9]` and bit 0 from `din[8]`. Input-stage bits 9:2 are kept.
- R5: With `xfer_n` low and `bsel` low at an edge, `code` shows the input-stage contents from the cycle after that edge.
- R6: With `xfer_n` low but `bsel` high, `code` does not change.
- R7: While `xfer_n` is high, `code` holds its value whatever the write inputs do.
- R8: When a write and a transfer occur at the same edge, `code` takes the input-stage value that includes that write (flow-through).
- R9: Writes act on their level. Holding `wr_n` low over several edges reloads the input stage at every edge, so the last data present is the data kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; enables writes |
| wr_n | input | 1 | Write strobe, active low |
| bsel | input | 1 | Byte select: high loads all bits on a write, low loads the two low bits and enables transfer |
| xfer_n | input | 1 | Transfer strobe, active low |
| din | input | 10 | Data inputs, left justified |
| code | output | 10 | Code held in the output register |

## Verification
The hardest case to reach is the same-edge interaction. In it, a low-byte write and a transfer land together, so the output must take the freshly merged value and not the stale staged one. Random stimulus reaches it only rarely. For that reason the bench drives it directly with distinct upper and lower data and then mixes it into the random phase with raised weight. A second case is a transfer attempted while byte-select is high after new data has been staged. Directed steps set this up, and the bench then checks that the output keeps its old code.

// File: rtl/dbdac_pkg.sv
package dbdac_pkg;
   // width of the narrow section that the second byte overwrites
   function automatic int lo_width(input int code_w, input int bus_w);
      return code_w - bus_w;
   endfunction
endpackage

// File: rtl/dbdac_in_latch.sv
module dbdac_in_latch #(
   parameter int CODE_W     = 10,
   parameter int BUS_W      = 8,
   parameter bit BYTE2_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wen,
   input  logic              full,
   input  logic [CODE_W-1:0] d,
   output logic [CODE_W-1:0] q,
   output logic [CODE_W-1:0] q_next
);
   localparam int LO_W = dbdac_pkg::lo_width(CODE_W, BUS_W);

   if (LO_W < 1) begin : g_bad_split
      $error("dbdac_in_latch: CODE_W must exceed BUS_W");
   end

   logic [LO_W-1:0] lo_src;

   // choose which data lines feed the narrow section on a second byte
   if (BYTE2_HIGH) begin : g_lo_top
      assign lo_src = d[CODE_W-1 -: LO_W];
   end else begin : g_lo_bot
      assign lo_src = d[LO_W-1:0];
   end

   always_comb begin
      q_next = q;
      if (wen) begin
         if (full) q_next = d;
         else      q_next[LO_W-1:0] = lo_src;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_next;
   end

   assert_cs_gate_R2: assert property (@(posedge clk) disable iff (rst)
      !wen |=> $stable(q));
   assert_hi_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (wen && !full) |=> $stable(q[CODE_W-1:LO_W]));
   assert_full_load_R3: assert property (@(posedge clk) disable iff (rst)
      (wen && full) |=> q == $past(d));
endmodule

// File: rtl/dbdac_hold_reg.sv
module dbdac_hold_reg #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] d,
   output logic [CODE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
endmodule

// File: rtl/dbdac_front.sv
module dbdac_front #(
   parameter int CODE_W     = 10,
   parameter int BUS_W      = 8,
   parameter bit BYTE2_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              bsel,
   input  logic              xfer_n,
   input  logic [CODE_W-1:0] din,
   output logic [CODE_W-1:0] code
);
   logic              wen, xfer_ok;
   logic [CODE_W-1:0] stage_q, stage_next;

   assign wen     = !cs_n && !wr_n;
   assign xfer_ok = !xfer_n && !bsel;

   dbdac_in_latch #(
      .CODE_W(CODE_W), .BUS_W(BUS_W), .BYTE2_HIGH(BYTE2_HIGH)
   ) u_stage (
      .clk(clk), .rst(rst), .wen(wen), .full(bsel),
      .d(din), .q(stage_q), .q_next(stage_next)
   );

   dbdac_hold_reg #(.CODE_W(CODE_W)) u_out (
      .clk(clk), .rst(rst), .load(xfer_ok), .d(stage_next), .q(code)
   );

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (code == '0 && stage_q == '0));
   assert_xfer_R5: assert property (@(posedge clk) disable iff (rst)
      (!xfer_n && !bsel) |=> code == stage_q);
   assert_bsel_block_R6: assert property (@(posedge clk) disable iff (rst)
      (!xfer_n && bsel) |=> $stable(code));
endmodule

// File: tb/sim_dbdac_front.sv
module sim_dbdac_front;
   logic       clk = 1'b0;
   logic       rst, cs_n, wr_n, bsel, xfer_n;
   logic [9:0] din;
   logic [9:0] code;
   logic [9:0] m_stage, m_code;
   int         n_chk = 0, n_err = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   dbdac_front u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n),
      .bsel(bsel), .xfer_n(xfer_n), .din(din), .code(code));

   function automatic logic [9:0] f_stage(logic [9:0] s, logic c, logic w,
                                          logic b, logic [9:0] d);
      if (c || w) return s;
      if (b) return d;
      return {s[9:2], d[9:8]};
   endfunction

   task automatic check(string req, logic [9:0] act, logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, update model at posedge, sample 1 ns later
   task automatic step(logic r, logic c, logic w, logic b, logic x, logic [9:0] d);
      @(negedge clk);
      rst = r; cs_n = c; wr_n = w; bsel = b; xfer_n = x; din = d;
      @(posedge clk);
      if (r) begin m_stage = '0; m_code = '0; end
      else begin
         m_stage = f_stage(m_stage, c, w, b, d);
         if (!x && !b) m_code = m_stage;
      end
      #1;
   endtask

   // bring the staged value to the output and compare it
   task automatic peek(string req);
      step(0, 1, 1, 0, 0, 10'h000);
      check(req, code, m_stage);
   endtask

   initial begin
      m_stage = '0; m_code = '0;
      step(1, 1, 1, 1, 1, 10'h3FF);
      check("R1", code, 10'h000);
      peek("R1");

      step(0, 0, 0, 1, 1, 10'h2D7);            // full write
      check("R7", code, 10'h000);
      peek("R3");                              // expect 2D7

      step(0, 1, 0, 1, 1, 10'h155);            // cs high
      peek("R2");                              // still 2D7

      step(0, 0, 0, 0, 1, 10'h200);            // low byte: bits 10
      peek("R4");                              // {2D7[9:2],2'b10} = 2D6

      step(0, 0, 0, 1, 1, 10'h0F0);
      step(0, 1, 1, 1, 0, 10'h000);            // xfer with bsel high
      check("R6", code, 10'h2D6);

      step(0, 0, 0, 0, 0, 10'h300);            // same-edge write + xfer
      check("R8", code, 10'h0F3);

      step(0, 0, 0, 1, 1, 10'h011);            // held write, level acting
      step(0, 0, 0, 1, 1, 10'h122);
      step(0, 0, 0, 1, 1, 10'h233);
      check("R7", code, 10'h0F3);
      peek("R9");                              // 233

      step(0, 0, 0, 1, 1, 10'h3C0);            // two-byte load via flow
      step(0, 0, 0, 0, 0, 10'h100);
      check("R8", code, 10'h3C1);

      for (int i = 0; i < 4000; i++) begin
         logic r, c, w, b, x;
         logic [9:0] d;
         r = ($urandom % 97) == 0;
         c = ($urandom % 4) == 0;
         w = ($urandom % 3) == 0;
         b = $urandom % 2;
         x = ($urandom % 3) != 0;
         d = 10'($urandom);
         step(r, c, w, b, x, d);
         if (r)              check("R1", code, m_code);
         else if (!x && !b && !c && !w) check("R8", code, m_code);
         else if (!x && !b)  check("R5", code, m_code);
         else if (!x)        check("R6", code, m_code);
         else                check("R7", code, m_code);
      end
      done = 1;
   end

   initial begin
      void'($urandom(32'd1357));
      fork
         wait (done);
         begin
            #(200000 * 5);
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule